// File: doc/BRIEF.md
# Dual-Line Bus Fault Diagnosis Monitor

This block watches a two-wire redundant serial bus. The receiver front end gives two filtered line levels, and the local transmitter gives its own output level. A logic 1 on any of these means dominant. The monitor keeps a registered three-bit diagnosis status. The status says whether the bus is healthy, whether one particular wire has failed, or whether the bus has a major error.

Three independent checks feed the status:
- A traffic check counts bus transitions between pulses of a slow diagnosis clock.
- A transmit cross-check runs while a transmission is in progress. It compares both received wires against a delayed copy of the transmitted level, and the wire that reads recessive while the other reads dominant is blamed.
- A stuck-dominant check counts consecutive dominant timeslots.

The diagnosis clock comes either from a divider on the timeslot strobe or from a manual strobe. In automatic selection the diagnosis clock also heals the status when traffic is healthy. In the three manual selections, the only way back to nominal is a return-to-idle pulse raised at end of frame.

Top module: `busdiag_monitor`

## Requirements
- R1: After reset the status is 000. The status only ever takes the codes 000 (nominal), 001 (line 1 faulty), 010 (line 2 faulty) and 111 (major error).
- R2: The bus counts as dominant when either line input is 1. On the clock edge that samples the eighth consecutive `ts_tick` with the bus dominant, the status becomes 111. Seven such ticks do not change it.
- R3: A `ts_tick` sampled with both lines at 0 (recessive) restarts the dominant-timeslot run from zero.
- R4: When a diagnosis clock pulse is sampled and fewer than 4 bus transitions were seen since the previous pulse (or since reset), the status becomes 111 on that edge.
- R5: With `sel_mode` 0 (automatic), a diagnosis clock pulse after 4 or more transitions sets the status to 000. The transition count restarts at every pulse. With `sel_mode` 1, 2 or 3 no such recovery happens.
- R6: With `div_val` = N, where N is not 0, the diagnosis clock fires on every Nth `ts_tick` counted from reset. With `div_val` 0, `man_strobe` is the diagnosis clock and `ts_tick` produces none.
- R7: `tip` and `tx_dom` are delayed by FILT_DLY (default 2) clock cycles. The comparison is active while the delayed `tip` is 1 and the delayed `tx_dom` is 1 or has just fallen from 1 to 0. If the lines disagree during that window, the recessive line is blamed: from 000 the status becomes 001 if line 1 is 0, or 010 if line 2 is 0. The status changes FILT_DLY+1 edges after the stimulus is applied.
- R8: No comparison takes place while the delayed `tip` is 0, or while the delayed `tx_dom` stays at 0. Disagreeing lines then leave the status unchanged.
- R9: A comparison that blames the other line while the status already shows a single-line fault sets the status to 111.
- R10: `ri_pulse` sets the status to 000 when `sel_mode` is 1, 2 or 3. It has no effect when `sel_mode` is 0.
- R11: In any cycle, a stuck-dominant or starved-traffic condition wins over `ri_pulse`, over automatic recovery and over comparison results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_tick | input | 1 | One-cycle strobe at each timeslot sample point |
| line1_dom | input | 1 | Filtered level of bus line 1, 1 = dominant |
| line2_dom | input | 1 | Filtered level of bus line 2, 1 = dominant |
| tx_dom | input | 1 | Local transmit level, 1 = dominant |
| tip | input | 1 | Transmission in progress; enables the cross-check |
| ri_pulse | input | 1 | Return-to-idle pulse from end-of-frame detection |
| sel_mode | input | 2 | 0 = automatic selection, 1..3 = manual selections |
| div_val | input | DIVW | Timeslots per diagnosis period; 0 selects the manual strobe |
| man_strobe | input | 1 | Manual diagnosis clock pulse |
| status | output | 3 | Registered diagnosis code |

## Verification
Timing of the results:
- The stuck-dominant, starvation, recovery and return-to-idle results all appear on the clock edge that samples the causing strobe. The bench drives each strobe for exactly one cycle after a falling edge and reads the status at the next falling edge.
- A cross-check result appears FILT_DLY+1 edges after the stimulus. The bench reads once after FILT_DLY edges, expecting no change yet, and once one edge later, expecting the new code.
- The fall-to-recessive window is one cycle wide. The bench opens it by presenting the disagreement exactly FILT_DLY cycles after dropping `tx_dom`.

Edge counts per period and timeslot run lengths are drawn at random with a fixed seed. Each expected code is produced by a bench function from those counts.

// File: rtl/busdiag_pkg.sv
package busdiag_pkg;
  typedef enum logic [2:0] {
    ST_NOM = 3'b000,
    ST_L1  = 3'b001,
    ST_L2  = 3'b010,
    ST_MAJ = 3'b111
  } diag_st_t;

  localparam logic [1:0] SEL_AUTO = 2'd0;
endpackage

// File: rtl/busdiag_dclk_gen.sv
// Diagnosis clock source: divider on the timeslot strobe, or a manual strobe
module busdiag_dclk_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ts_tick,
  input  logic [DIVW-1:0] div_val,
  input  logic            man_strobe,
  output logic            dclk
);
  localparam logic [DIVW-1:0] ONE = DIVW'(1);

  logic [DIVW-1:0] cnt;
  logic            manual;
  logic            wrap;

  assign manual = (div_val == '0);
  assign wrap   = (cnt >= div_val - ONE);

  always_comb begin
    if (manual) dclk = man_strobe;
    else        dclk = ts_tick && wrap;
  end

  always_ff @(posedge clk) begin
    if (rst || manual) begin
      cnt <= '0;
    end else if (ts_tick) begin
      cnt <= wrap ? '0 : cnt + ONE;
    end
  end
endmodule

// File: rtl/busdiag_edge_watch.sv
// Counts bus transitions per diagnosis period and judges the traffic
module busdiag_edge_watch #(
  parameter int EDGE_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bus,
  input  logic dclk,
  output logic starve,
  output logic healthy
);
  localparam int CW = $clog2(EDGE_MIN + 1);

  logic          bus_q;
  logic          bus_edge;
  logic [CW-1:0] cnt;
  logic [CW:0]   total;
  logic          enough;

  assign bus_edge = bus ^ bus_q;
  assign total    = {1'b0, cnt} + {{CW{1'b0}}, bus_edge};
  assign enough   = (total >= (CW+1)'(EDGE_MIN));
  assign starve   = dclk && !enough;
  assign healthy  = dclk && enough;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= 1'b0;
      cnt   <= '0;
    end else begin
      bus_q <= bus;
      if (dclk)
        cnt <= '0;
      else if (bus_edge && (cnt < CW'(EDGE_MIN)))
        cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/busdiag_dom_run.sv
// Consecutive dominant timeslot counter
module busdiag_dom_run #(
  parameter int RUN_LIM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ts_tick,
  input  logic bus,
  output logic stuck
);
  localparam int CW = $clog2(RUN_LIM);
  localparam logic [CW-1:0] TOP = CW'(RUN_LIM - 1);

  logic [CW-1:0] run;

  assign stuck = ts_tick && bus && (run == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (ts_tick) begin
      if (!bus)           run <= '0;
      else if (run != TOP) run <= run + CW'(1);
    end
  end
endmodule

// File: rtl/busdiag_tx_cmp.sv
// Cross-check of both received lines against the delayed transmit level
module busdiag_tx_cmp #(
  parameter int FILT_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tip,
  input  logic tx_dom,
  input  logic line1_dom,
  input  logic line2_dom,
  output logic bad1,
  output logic bad2
);
  localparam int TW = FILT_DLY + 1;

  logic [FILT_DLY-1:0] tip_sh;
  logic [TW-1:0]       tx_sh;
  logic                tip_d;
  logic                tx_d;
  logic                tx_p;
  logic                window;

  assign tip_d  = tip_sh[FILT_DLY-1];
  assign tx_d   = tx_sh[FILT_DLY-1];
  assign tx_p   = tx_sh[FILT_DLY];
  assign window = tip_d && (tx_d || tx_p);
  assign bad1   = window && !line1_dom && line2_dom;
  assign bad2   = window && line1_dom && !line2_dom;

  always_ff @(posedge clk) begin
    if (rst) begin
      tip_sh <= '0;
      tx_sh  <= '0;
    end else begin
      tip_sh <= (tip_sh << 1) | FILT_DLY'(tip);
      tx_sh  <= (tx_sh << 1) | TW'(tx_dom);
    end
  end
endmodule

// File: rtl/busdiag_monitor.sv
module busdiag_monitor
  import busdiag_pkg::*;
#(
  parameter int DIVW     = 8,
  parameter int EDGE_MIN = 4,
  parameter int RUN_LIM  = 8,
  parameter int FILT_DLY = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ts_tick,
  input  logic            line1_dom,
  input  logic            line2_dom,
  input  logic            tx_dom,
  input  logic            tip,
  input  logic            ri_pulse,
  input  logic [1:0]      sel_mode,
  input  logic [DIVW-1:0] div_val,
  input  logic            man_strobe,
  output logic [2:0]      status
);
  logic     bus;
  logic     dclk;
  logic     starve;
  logic     healthy;
  logic     stuck;
  logic     bad1;
  logic     bad2;
  logic     auto_sel;
  diag_st_t st_q;
  diag_st_t st_d;

  assign bus      = line1_dom | line2_dom;
  assign auto_sel = (sel_mode == SEL_AUTO);

  busdiag_dclk_gen #(.DIVW(DIVW)) u_dclk (
    .clk(clk), .rst(rst), .ts_tick(ts_tick), .div_val(div_val),
    .man_strobe(man_strobe), .dclk(dclk)
  );

  busdiag_edge_watch #(.EDGE_MIN(EDGE_MIN)) u_edge (
    .clk(clk), .rst(rst), .bus(bus), .dclk(dclk),
    .starve(starve), .healthy(healthy)
  );

  busdiag_dom_run #(.RUN_LIM(RUN_LIM)) u_run (
    .clk(clk), .rst(rst), .ts_tick(ts_tick), .bus(bus), .stuck(stuck)
  );

  busdiag_tx_cmp #(.FILT_DLY(FILT_DLY)) u_cmp (
    .clk(clk), .rst(rst), .tip(tip), .tx_dom(tx_dom),
    .line1_dom(line1_dom), .line2_dom(line2_dom), .bad1(bad1), .bad2(bad2)
  );

  // Priority: major causes, then recovery, then line blame
  always_comb begin
    st_d = st_q;
    if (stuck || starve) begin
      st_d = ST_MAJ;
    end else if (auto_sel && healthy) begin
      st_d = ST_NOM;
    end else if (!auto_sel && ri_pulse) begin
      st_d = ST_NOM;
    end else if (bad1) begin
      case (st_q)
        ST_NOM:  st_d = ST_L1;
        ST_L2:   st_d = ST_MAJ;
        default: st_d = st_q;
      endcase
    end else if (bad2) begin
      case (st_q)
        ST_NOM:  st_d = ST_L2;
        ST_L1:   st_d = ST_MAJ;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_NOM;
    else     st_q <= st_d;
  end

  assign status = st_q;
endmodule

// File: rtl/busdiag_checker.sv
module busdiag_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] sel_mode,
  input logic       ri_pulse,
  input logic [2:0] status,
  input logic       stuck,
  input logic       starve,
  input logic       healthy,
  input logic       bad1,
  input logic       bad2
);
  logic major_cause;
  logic recover;

  assign major_cause = stuck || starve;
  assign recover     = (sel_mode == 2'd0) ? healthy : ri_pulse;

  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    (status == 3'b000 || status == 3'b001 || status == 3'b010 || status == 3'b111));

  p_stuck_major_r2: assert property (@(posedge clk) disable iff (rst)
    stuck |=> (status == 3'b111));

  p_starve_major_r4: assert property (@(posedge clk) disable iff (rst)
    starve |=> (status == 3'b111));

  p_auto_heal_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_mode == 2'd0 && healthy && !stuck) |=> (status == 3'b000));

  p_blame_line1_r7: assert property (@(posedge clk) disable iff (rst)
    (status == 3'b000 && bad1 && !major_cause && !recover) |=> (status == 3'b001));

  p_second_line_r9: assert property (@(posedge clk) disable iff (rst)
    (status == 3'b001 && bad2 && !major_cause && !recover) |=> (status == 3'b111));

  p_ri_manual_r10: assert property (@(posedge clk) disable iff (rst)
    (sel_mode != 2'd0 && ri_pulse && !major_cause) |=> (status == 3'b000));

  p_ri_auto_r10: assert property (@(posedge clk) disable iff (rst)
    (sel_mode == 2'd0 && ri_pulse && !major_cause && !healthy && !bad1 && !bad2)
      |=> $stable(status));

  p_cause_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (major_cause && ri_pulse) |=> (status == 3'b111));
endmodule

bind busdiag_monitor busdiag_checker i_chk (
  .clk(clk), .rst(rst), .sel_mode(sel_mode), .ri_pulse(ri_pulse),
  .status(status), .stuck(stuck), .starve(starve), .healthy(healthy),
  .bad1(bad1), .bad2(bad2)
);

// File: tb/test_busdiag_monitor.sv
module test_busdiag_monitor;
  localparam int CLK_PER  = 10;
  localparam int DIVW     = 8;
  localparam int FILT_DLY = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ts_tick = 1'b0;
  logic            line1_dom = 1'b0;
  logic            line2_dom = 1'b0;
  logic            tx_dom = 1'b0;
  logic            tip = 1'b0;
  logic            ri_pulse = 1'b0;
  logic [1:0]      sel_mode = 2'd0;
  logic [DIVW-1:0] div_val = '0;
  logic            man_strobe = 1'b0;
  logic [2:0]      status;

  int n_chk  = 0;
  int n_fail = 0;

  busdiag_monitor #(.DIVW(DIVW), .FILT_DLY(FILT_DLY)) i_busdiag_monitor (
    .clk(clk), .rst(rst), .ts_tick(ts_tick), .line1_dom(line1_dom),
    .line2_dom(line2_dom), .tx_dom(tx_dom), .tip(tip), .ri_pulse(ri_pulse),
    .sel_mode(sel_mode), .div_val(div_val), .man_strobe(man_strobe),
    .status(status)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [2:0] exp_after_period(input int edges);
    return (edges < 4) ? 3'b111 : 3'b000;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if (status !== exp) begin
      n_fail++;
      $display("FAIL %s: status=%b expected=%b at %0t", req, status, exp, $time);
    end
  endtask

  task automatic tick();
    ts_tick = 1'b1; cyc(1); ts_tick = 1'b0;
  endtask

  task automatic ri();
    ri_pulse = 1'b1; cyc(1); ri_pulse = 1'b0;
  endtask

  task automatic strobe();
    man_strobe = 1'b1; cyc(1); man_strobe = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin
    int k;
    int n;
    int e;
    k = $urandom(32'h5eed);
    cyc(2);
    rst = 1'b0;
    cyc(1);
    check("R1 reset state", 3'b000);

    // R2 / R3: dominant timeslot runs, manual selection, no diagnosis clock
    sel_mode = 2'd1;
    line1_dom = 1'b1; line2_dom = 1'b1;
    k = 1 + int'($urandom % 7);
    repeat (k) tick();
    check("R2 short dominant run", 3'b000);
    line1_dom = 1'b0; line2_dom = 1'b0;
    tick();
    line2_dom = 1'b1;
    repeat (7) tick();
    check("R3 run restarted by recessive slot", 3'b000);
    tick();
    check("R2 eighth dominant slot", 3'b111);

    // R10: return-to-idle ignored in automatic, honoured in manual
    sel_mode = 2'd0;
    ri();
    check("R10 ri ignored in auto", 3'b111);
    sel_mode = 2'd3;
    ri();
    check("R10 ri in manual", 3'b000);

    // R11: stuck run still active, tick together with ri
    ts_tick = 1'b1; ri_pulse = 1'b1; cyc(1); ts_tick = 1'b0; ri_pulse = 1'b0;
    check("R11 stuck beats ri", 3'b111);
    line2_dom = 1'b0;
    tick();
    ri();
    check("R10 ri clears again", 3'b000);

    // R7: cross-check with filter delay, line 1 recessive
    sel_mode = 2'd1;
    tip = 1'b1; tx_dom = 1'b1; line1_dom = 1'b0; line2_dom = 1'b1;
    cyc(FILT_DLY);
    check("R7 not before filter delay", 3'b000);
    cyc(1);
    check("R7 line 1 blamed", 3'b001);
    line1_dom = 1'b1; line2_dom = 1'b0;
    cyc(1);
    check("R9 second line blamed", 3'b111);

    tip = 1'b0; tx_dom = 1'b0; line1_dom = 1'b0; line2_dom = 1'b0;
    cyc(FILT_DLY + 2);
    ri();
    tx_dom = 1'b1; line2_dom = 1'b1;
    cyc(FILT_DLY + 3);
    check("R8 no compare without tip", 3'b000);
    tx_dom = 1'b0;
    cyc(FILT_DLY + 3);
    tip = 1'b1;
    cyc(FILT_DLY + 3);
    check("R8 no compare on steady recessive", 3'b000);

    // R7: one-cycle window after release to recessive, line 2 recessive
    tx_dom = 1'b1; line1_dom = 1'b1; line2_dom = 1'b1;
    cyc(FILT_DLY + 2);
    tx_dom = 1'b0;
    cyc(FILT_DLY);
    line2_dom = 1'b0;
    cyc(1);
    line1_dom = 1'b0;
    cyc(2);
    check("R7 release window blames line 2", 3'b010);
    tip = 1'b0;
    cyc(FILT_DLY + 2);

    // R6 / R4: divider on timeslot strobe, no traffic
    do_reset();
    sel_mode = 2'd0;
    n = 3 + int'($urandom % 4);
    div_val = DIVW'(n);
    repeat (n - 1) tick();
    check("R6 divider not yet expired", 3'b000);
    tick();
    check("R4 starved at divider period", 3'b111);

    // R6: zero divider selects manual strobe
    do_reset();
    div_val = '0;
    repeat (20) tick();
    check("R6 ticks ignored with zero divider", 3'b000);
    strobe();
    check("R6 manual strobe starves", 3'b111);

    // R4 / R5: edge counts per strobe period, automatic selection
    for (int p = 0; p < 10; p++) begin
      case (p)
        0: e = 4;
        1: e = 3;
        2: e = 5;
        3: e = 0;
        default: e = int'($urandom % 8);
      endcase
      for (int j = 0; j < e; j++) begin
        line1_dom = ~line1_dom;
        cyc(2);
      end
      strobe();
      check((e < 4) ? "R4 too few edges" : "R5 healthy period recovers",
            exp_after_period(e));
    end

    // R5: no recovery in manual selection
    strobe();
    check("R4 empty period", 3'b111);
    sel_mode = 2'd2;
    for (int j = 0; j < 6; j++) begin
      line1_dom = ~line1_dom;
      cyc(2);
    end
    strobe();
    check("R5 no recovery in manual", 3'b111);

    report();
    $finish;
  end
endmodule